// File: doc/BRIEF.md
# Banked Vector Operand Collector

This block feeds a four-lane vector ALU with its three source operands. Register storage is split into four single-component banks. Lane 0 (x) sits in bank 0, lane 1 (y) in bank 1, lane 2 (z) in bank 2 and lane 3 (w) in bank 3. Each bank has exactly one read port and one write port. The ALU never reads a bank directly. It reads three vec4 staging registers, called collectors, which the block fills one operand per cycle.

Time is divided into fixed four-cycle periods that run freely from reset:

| Cycle in period | Action |
|---|---|
| 0 | Gather operand A |
| 1 | Gather operand B |
| 2 | Gather operand C |
| 3 | Write-back slot: the only cycle in which the block takes a new gather request or a write-back item |

A request presents three register numbers on a valid/ready stream. A write-back item presents a register number, a vec4 of data and a four-bit lane mask on a second valid/ready stream.

Back-pressure rules apply to both input streams:
- A producer that raises valid keeps valid and every payload bit unchanged until it sees ready high at a rising clock edge. The item is taken at that edge.
- Ready never depends on valid.
- A request raised in the middle of a period is therefore held off until the period's last cycle.

The assembled operands and their valid flag form a plain status output with no back-pressure.

Top module: `vec_operand_collector`

## Requirements
- R1: After reset, opnd_valid, req_ready and wb_ready are 0, every collector lane reads 0, and every bank entry holds 0.
- R2: req_ready and wb_ready are high in exactly one cycle out of every four: the cycle in which the third negative clock edge after reset release falls, and every fourth cycle after it. They are never high in two consecutive cycles.
- R3: A request raised in the first cycle of a period is not taken until the last cycle of that period, three cycles later. While it waits, req_ready stays 0.
- R4: For an accepted request (a, b, c), lane l of opnd_a, opnd_b and opnd_c equals entry a, b and c of bank l respectively. Lane l occupies bits [16*l+15 : 16*l] with the default width.
- R5: opnd_valid rises three clock edges after the edge that accepts a request, which is the cycle after operand C is gathered. It stays high until the edge that accepts the next request, where it falls.
- R6: A write-back item changes only the banks whose bit is set in wb_mask (bit l selects bank l). With a zero mask, no entry changes.
- R7: A register written in a write-back slot returns the new data to any read in a later period. This includes a request accepted at the same edge as the write.
- R8: While opnd_valid is high and no new request is accepted, opnd_a, opnd_b and opnd_c keep their values.
- R9: A write-back item offered while wb_ready is 0 is not written until the write-back slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Gather request present |
| req_ready | output | 1 | Request taken at this edge (write-back slot) |
| req_addr_a | input | AW | Register number for operand A |
| req_addr_b | input | AW | Register number for operand B |
| req_addr_c | input | AW | Register number for operand C |
| wb_valid | input | 1 | Write-back item present |
| wb_ready | output | 1 | Write-back taken at this edge |
| wb_addr | input | AW | Register number to write |
| wb_mask | input | LANES | Per-lane write enable; bit l selects bank l |
| wb_data | input | LANES*DATA_W | Data to write; lane l at [l*DATA_W +: DATA_W] |
| opnd_valid | output | 1 | All three collectors hold the current request |
| opnd_a | output | LANES*DATA_W | Collector A |
| opnd_b | output | LANES*DATA_W | Collector B |
| opnd_c | output | LANES*DATA_W | Collector C |

## Verification
The bench aims at the following corner cases:

- **Same register in all three slots.** The bench gathers one register as A, B and C. A design that muxed lanes or slots wrongly would produce mismatched collectors.
- **Write and read accepted at the same edge.** The bench issues a write-back and a read of the same register together. A design that read before writing, or wrote in a gather cycle, would return the stale value.
- **Partial and empty write masks.** A design that ignored the mask would corrupt the untouched lanes.
- **Mid-period requests.** A design that took a request early would raise opnd_valid a cycle too soon.
- **Idle gaps.** A design that recaptured its collectors during a gap would drift from the held operands.

// File: rtl/opc_pkg.sv
package opc_pkg;
  localparam int OPND_N = 3;

  typedef enum logic [1:0] {
    PH_RD_A = 2'd0,
    PH_RD_B = 2'd1,
    PH_RD_C = 2'd2,
    PH_WB   = 2'd3
  } phase_e;
endpackage

// File: rtl/opc_sequencer.sv
module opc_sequencer
  import opc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr_a,
  input  logic [AW-1:0] req_addr_b,
  input  logic [AW-1:0] req_addr_c,
  output logic          req_ready,
  output logic          wb_ready,
  output logic [AW-1:0] rd_addr,
  output logic          cap_en,
  output logic [1:0]    cap_sel,
  output logic          opnd_valid
);
  phase_e        phase_q;
  logic          busy_q;
  logic          valid_q;
  logic [AW-1:0] addr_q [OPND_N];
  logic          req_fire;

  assign req_ready = (phase_q == PH_WB);
  assign wb_ready  = (phase_q == PH_WB);
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_RD_A;
    else        phase_q <= phase_e'(phase_q + 2'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      for (int i = 0; i < OPND_N; i++) addr_q[i] <= '0;
    end else if (req_fire) begin
      busy_q    <= 1'b1;
      valid_q   <= 1'b0;
      addr_q[0] <= req_addr_a;
      addr_q[1] <= req_addr_b;
      addr_q[2] <= req_addr_c;
    end else if (busy_q && phase_q == PH_RD_C) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b1;
    end
  end

  always_comb begin
    case (phase_q)
      PH_RD_A: rd_addr = addr_q[0];
      PH_RD_B: rd_addr = addr_q[1];
      PH_RD_C: rd_addr = addr_q[2];
      default: rd_addr = '0;
    endcase
  end

  assign cap_en     = busy_q && (phase_q != PH_WB);
  assign cap_sel    = phase_q;
  assign opnd_valid = valid_q;

  AST_READY_ONE_IN_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R2
  AST_START_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !opnd_valid); // R5
  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_valid && !req_fire) |=> opnd_valid); // R5
  AST_VALID_AFTER_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(opnd_valid) |-> ($past(cap_en) && $past(cap_sel) == 2'd2)); // R5
endmodule

// File: rtl/opc_bank.sv
module opc_bank #(
  parameter int DATA_W = 16,
  parameter int REGS   = 16,
  parameter int AW     = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem_q [REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data))); // R7
endmodule

// File: rtl/opc_lane_collect.sv
module opc_lane_collect #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [1:0]        cap_sel,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] col_a,
  output logic [DATA_W-1:0] col_b,
  output logic [DATA_W-1:0] col_c
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_a <= '0;
      col_b <= '0;
      col_c <= '0;
    end else if (cap_en) begin
      case (cap_sel)
        2'd0:    col_a <= rd_data;
        2'd1:    col_b <= rd_data;
        2'd2:    col_c <= rd_data;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vec_operand_collector.sv
module vec_operand_collector #(
  parameter int DATA_W = 16,
  parameter int LANES  = 4,
  parameter int REGS   = 16,
  parameter int AW     = $clog2(REGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [AW-1:0]           req_addr_a,
  input  logic [AW-1:0]           req_addr_b,
  input  logic [AW-1:0]           req_addr_c,
  input  logic                    wb_valid,
  output logic                    wb_ready,
  input  logic [AW-1:0]           wb_addr,
  input  logic [LANES-1:0]        wb_mask,
  input  logic [LANES*DATA_W-1:0] wb_data,
  output logic                    opnd_valid,
  output logic [LANES*DATA_W-1:0] opnd_a,
  output logic [LANES*DATA_W-1:0] opnd_b,
  output logic [LANES*DATA_W-1:0] opnd_c
);
  logic [AW-1:0] rd_addr;
  logic          cap_en;
  logic [1:0]    cap_sel;
  logic          wb_fire;

  assign wb_fire = wb_valid && wb_ready;

  opc_sequencer #(.AW(AW)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr_a (req_addr_a),
    .req_addr_b (req_addr_b),
    .req_addr_c (req_addr_c),
    .req_ready  (req_ready),
    .wb_ready   (wb_ready),
    .rd_addr    (rd_addr),
    .cap_en     (cap_en),
    .cap_sel    (cap_sel),
    .opnd_valid (opnd_valid)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DATA_W-1:0] bank_rd;

    opc_bank #(.DATA_W(DATA_W), .REGS(REGS), .AW(AW)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (rd_addr),
      .rd_data (bank_rd),
      .wr_en   (wb_fire && wb_mask[l]),
      .wr_addr (wb_addr),
      .wr_data (wb_data[l*DATA_W +: DATA_W])
    );

    opc_lane_collect #(.DATA_W(DATA_W)) i_col (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (cap_en),
      .cap_sel (cap_sel),
      .rd_data (bank_rd),
      .col_a   (opnd_a[l*DATA_W +: DATA_W]),
      .col_b   (opnd_b[l*DATA_W +: DATA_W]),
      .col_c   (opnd_c[l*DATA_W +: DATA_W])
    );
  end

  AST_OPND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (opnd_valid && !(req_valid && req_ready)) |=>
      ($stable(opnd_a) && $stable(opnd_b) && $stable(opnd_c))); // R8
  AST_WB_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_ready |=> !wb_ready); // R9
endmodule

// File: tb/test_vec_operand_collector.sv
module test_vec_operand_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_addr_a = '0, req_addr_b = '0, req_addr_c = '0;
  logic        wb_valid = 1'b0;
  logic        wb_ready;
  logic [3:0]  wb_addr = '0;
  logic [3:0]  wb_mask = '0;
  logic [63:0] wb_data = '0;
  logic        opnd_valid;
  logic [63:0] opnd_a, opnd_b, opnd_c;

  vec_operand_collector i_vec_operand_collector (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr_a(req_addr_a), .req_addr_b(req_addr_b), .req_addr_c(req_addr_c),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr),
    .wb_mask(wb_mask), .wb_data(wb_data),
    .opnd_valid(opnd_valid), .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [15:0] model [16][4];
  logic [63:0] q_a[$], q_b[$], q_c[$];
  int          q_cyc[$];
  logic [63:0] last_a, last_b, last_c;
  logic        prev_v = 1'b0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input int r);
    return {model[r][3], model[r][2], model[r][1], model[r][0]};
  endfunction

  task automatic issue(input bit rd, input int a, input int b, input int c,
                       input bit wr, input int wa, input logic [63:0] wd,
                       input logic [3:0] wm, output int waited);
    req_valid = rd; req_addr_a = 4'(a); req_addr_b = 4'(b); req_addr_c = 4'(c);
    wb_valid = wr; wb_addr = 4'(wa); wb_data = wd; wb_mask = wm;
    waited = 0;
    while (!req_ready) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    if (wr) for (int l = 0; l < 4; l++) if (wm[l]) model[wa][l] = wd[l*16 +: 16];
    if (rd) begin
      q_a.push_back(pack(a)); q_b.push_back(pack(b)); q_c.push_back(pack(c));
      q_cyc.push_back(cyc);
    end
    req_valid = 1'b0; wb_valid = 1'b0;
  endtask

  // Monitor: scoreboard pop on each rise of opnd_valid (R4, R5)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (opnd_valid && !prev_v) begin
        if (q_a.size() == 0) begin
          check(1'b0, "R5 unexpected valid", 64'(opnd_valid), 64'd0);
        end else begin
          int k;
          logic [63:0] ea, eb, ec;
          ea = q_a.pop_front(); eb = q_b.pop_front(); ec = q_c.pop_front();
          k = q_cyc.pop_front();
          check(cyc == k + 3, "R5 valid timing", 64'(cyc), 64'(k + 3));
          check(opnd_a == ea, "R4 opnd_a", opnd_a, ea);
          check(opnd_b == eb, "R4 opnd_b", opnd_b, eb);
          check(opnd_c == ec, "R4 opnd_c", opnd_c, ec);
          last_a = ea; last_b = eb; last_c = ec;
        end
      end
      prev_v = opnd_valid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w;
    for (int r = 0; r < 16; r++) for (int l = 0; l < 4; l++) model[r][l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(opnd_valid == 1'b0, "R1 opnd_valid", 64'(opnd_valid), 64'd0);
    check(req_ready == 1'b0 && wb_ready == 1'b0, "R1 ready", 64'({req_ready, wb_ready}), 64'd0);
    check(opnd_a == '0 && opnd_b == '0 && opnd_c == '0, "R1 collectors", opnd_a | opnd_b | opnd_c, 64'd0);
    // R2: ready in one cycle of four
    for (int i = 0; i < 9; i++) begin
      if (i > 0) @(negedge clk);
      check(req_ready == (i % 4 == 3) && wb_ready == req_ready, "R2 ready cadence",
            64'(req_ready), 64'(i % 4 == 3));
    end
    // R1: read of fresh banks returns zeros
    issue(1, 9, 10, 11, 0, 0, '0, '0, w);
    // fill registers 0..7
    for (int r = 0; r < 8; r++) begin
      logic [63:0] d;
      for (int l = 0; l < 4; l++) d[l*16 +: 16] = 16'(16'h1000 * l + r * 17 + 1);
      issue(0, 0, 0, 0, 1, r, d, 4'b1111, w);
    end
    issue(1, 1, 2, 3, 0, 0, '0, '0, w);
    // R3: driven at start of a period, waits three cycles
    check(w == 3, "R3 held to boundary", 64'(w), 64'd3);
    issue(1, 7, 0, 5, 0, 0, '0, '0, w);
    issue(1, 3, 3, 3, 0, 0, '0, '0, w);
    // R6: partial mask
    issue(0, 0, 0, 0, 1, 2, 64'hAAAA_BBBB_CCCC_DDDD, 4'b0101, w);
    issue(1, 2, 1, 2, 0, 0, '0, '0, w);
    // R6 / R9: zero mask write leaves entry unchanged
    issue(0, 0, 0, 0, 1, 4, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0000, w);
    issue(1, 4, 4, 6, 0, 0, '0, '0, w);
    // R9: write offered mid-period waits for slot
    issue(0, 0, 0, 0, 1, 6, 64'h0123_4567_89AB_CDEF, 4'b1111, w);
    check(w == 3, "R9 write held to slot", 64'(w), 64'd3);
    // R7: write and read of same register accepted together
    issue(1, 5, 6, 5, 1, 5, 64'h5555_6666_7777_8888, 4'b1111, w);
    // R8: operands held over an idle gap
    repeat (14) @(negedge clk);
    check(opnd_valid == 1'b1, "R8 valid held", 64'(opnd_valid), 64'd1);
    check(opnd_a == last_a, "R8 opnd_a held", opnd_a, last_a);
    check(opnd_c == last_c, "R8 opnd_c held", opnd_c, last_c);
    check(opnd_a == 64'h5555_6666_7777_8888, "R7 new data", opnd_a, 64'h5555_6666_7777_8888);
    check(q_a.size() == 0, "R5 all results seen", 64'(q_a.size()), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule